// File: doc/BRIEF.md
# Parallel Camera Capture Frontend

This block takes a parallel camera stream and turns it into a cropped pixel stream. The input is a pixel clock, a vertical sync, a horizontal reference and a data bus. All four are sampled on the system clock. The selected edge of the pixel clock is found by comparing two consecutive samples of it. When the parallel bus is selected, each of the three control inputs can have its sense inverted. A vertical sync that becomes active starts a frame. While the horizontal reference is active, pixels are counted along the line. Each time the reference drops at the end of a line, the line counter advances.

The crop window is set by a left offset, a top offset, a right remainder and a bottom remainder, all measured from the edges of the programmed frame. Pixels inside the window are emitted as one-cycle `out_valid` pulses, with start-of-frame and end-of-frame markers on the first and last window pixel. The sink raises `out_ready` to say it has room. If a window pixel arrives while `out_ready` is low, that pixel is dropped and the overflow flag is set.

Capture enable is only looked at when a frame starts, so a frame is always emitted whole or not at all. A colour-bar generator can take the place of the sensor data. Four sticky event flags drive a single interrupt line. Each flag has a disable bit, and the output mode decides which flags may raise the interrupt at all.

Top module: `cam_crop_front`

## Requirements
- R1: After reset, `out_valid`, `out_sof`, `out_eof`, `irq` and all four bits of `sts_pend` are 0.
- R2: With `cfg_parallel`=1, `cfg_pclk_fall` makes the falling edge of `cam_pclk` the sampling edge, `cfg_vsync_low` makes `cam_vsync` active-low and `cfg_href_low` makes `cam_href` active-low. Each of the three bits acts on its own signal only.
- R3: With `cfg_parallel`=0, the three polarity bits have no effect: sampling is on the rising edge and both syncs are active-high.
- R4: With `cfg_crop_en`=1, the emitted pixels are exactly the raster-order pixels with column in [left, frame_w-right) and line in [top, frame_h-bottom).
- R5: With `cfg_crop_en`=0, the four offsets are ignored and every pixel of the frame_w by frame_h frame is emitted.
- R6: `out_sof` is high only with the first emitted pixel of a frame, and `out_eof` only with the last window pixel. Neither is ever high without `out_valid`.
- R7: `cfg_capture_en` is sampled when vsync becomes active. A frame that starts with it clear emits nothing. Clearing it in the middle of a frame still lets that frame finish.
- R8: A window pixel that arrives while `out_ready` is low is not emitted, and it sets overflow flag `sts_pend[0]`. `out_valid` is only ever high in the cycle after `out_ready` was high.
- R9: The flags in `sts_pend` are sticky: bit 0 is overflow, bit 1 is last-capture (a captured frame ended while `cfg_capture_en` was clear), bit 2 is frame start (a frame began with capture enabled), and bit 3 is frame end (the last window pixel of a captured frame). A flag clears only in response to a one-cycle pulse on the matching `sts_clr` bit.
- R10: `irq` is the OR of the pending flags that are enabled. A flag is enabled when its `cfg_irq_dis` bit is 0. In addition, when `cfg_to_mem`=0 only bits 0 and 1 can be enabled; when `cfg_to_mem`=1 all four can.
- R11: With `cfg_test_bars`=1 and a window width W of at least 8, the pixel at window column k carries (7-floor(8k/W))*floor((2^DW-1)/7) in place of sensor data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cam_pclk | input | 1 | Camera pixel clock, sampled as data |
| cam_vsync | input | 1 | Vertical sync |
| cam_href | input | 1 | Horizontal reference (line valid) |
| cam_data | input | DW | Pixel data |
| cfg_parallel | input | 1 | Parallel bus selected (polarity bits apply) |
| cfg_pclk_fall | input | 1 | Sample on the falling pixel clock edge |
| cfg_vsync_low | input | 1 | Vertical sync active low |
| cfg_href_low | input | 1 | Horizontal reference active low |
| cfg_frame_w | input | CW | Source frame width in pixels |
| cfg_frame_h | input | CW | Source frame height in lines |
| cfg_crop_en | input | 1 | Apply the crop offsets |
| cfg_off_left | input | CW | Columns skipped on the left |
| cfg_off_top | input | CW | Lines skipped at the top |
| cfg_rem_right | input | CW | Columns skipped on the right |
| cfg_rem_bottom | input | CW | Lines skipped at the bottom |
| cfg_capture_en | input | 1 | Capture enable, taken at frame start |
| cfg_test_bars | input | 1 | Replace data with colour bars |
| cfg_to_mem | input | 1 | Output mode: 1 memory, 0 downstream path |
| cfg_irq_dis | input | 4 | Per-flag interrupt disable (1 = disabled) |
| sts_clr | input | 4 | One-cycle pulse clears the matching flag |
| out_ready | input | 1 | Sink has room for a pixel |
| out_valid | output | 1 | One-cycle pixel strobe |
| out_data | output | DW | Pixel value |
| out_sof | output | 1 | First pixel of the frame |
| out_eof | output | 1 | Last pixel of the frame |
| sts_pend | output | 4 | Sticky flags: 0 overflow, 1 last, 2 start, 3 end |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `out_ready` is stable for as long as a pixel is being sampled, and that pixel clock edges are several system clocks apart. Without this, the edge detector could merge or miss pixels. They also assume the configuration stays fixed during a frame, except for capture enable, and that the offsets always describe a window that fits inside the frame. The stimulus drives each pixel clock phase for at least two system clocks and changes data, syncs and ready only away from the sampling edge. It changes the configuration only between frames, and its crop settings always leave a window at least eight pixels wide.

// File: rtl/cam_front_pkg.sv
package cam_front_pkg;
    localparam int NUM_EV   = 4;
    localparam int EV_OVF   = 0;
    localparam int EV_LAST  = 1;
    localparam int EV_START = 2;
    localparam int EV_END   = 3;
    localparam int NUM_BARS = 8;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/cam_sync_edge.sv
module cam_sync_edge #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cam_pclk,
    input  logic          cam_vsync,
    input  logic          cam_href,
    input  logic [DW-1:0] cam_data,
    input  logic          sel_par,
    input  logic          inv_pclk,
    input  logic          inv_vs,
    input  logic          inv_hr,
    output logic          pix_stb,
    output logic          vs_act,
    output logic          hr_act,
    output logic [DW-1:0] pix_data
);
    typedef struct packed {
        logic [DW-1:0] dat;
        logic          pclk;
        logic          pclk_prev;
        logic          vs;
        logic          hr;
    } sync_t;

    sync_t s_d, s_q;
    logic  fall_mode;

    always_comb begin
        s_d           = s_q;
        s_d.dat       = cam_data;
        s_d.pclk      = cam_pclk;
        s_d.pclk_prev = s_q.pclk;
        s_d.vs        = cam_vsync;
        s_d.hr        = cam_href;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Polarity bits only count on the parallel bus
    assign fall_mode = sel_par & inv_pclk;
    assign pix_stb   = fall_mode ? (s_q.pclk_prev & ~s_q.pclk)
                                 : (~s_q.pclk_prev & s_q.pclk);
    assign vs_act    = s_q.vs ^ (sel_par & inv_vs);
    assign hr_act    = s_q.hr ^ (sel_par & inv_hr);
    assign pix_data  = s_q.dat;
endmodule

// File: rtl/cam_window.sv
module cam_window #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          vs,
    input  logic          hr,
    input  logic          crop_en,
    input  logic [CW-1:0] frame_w,
    input  logic [CW-1:0] frame_h,
    input  logic [CW-1:0] off_l,
    input  logic [CW-1:0] off_t,
    input  logic [CW-1:0] rem_r,
    input  logic [CW-1:0] rem_b,
    output logic          in_win,
    output logic          at_first,
    output logic          at_last,
    output logic          frame_go,
    output logic          line_idle,
    output logic [CW-1:0] win_w
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic          vs_prev;
        logic          hr_prev;
    } pos_t;

    pos_t p_d, p_q;
    logic [CW-1:0] lo_x, lo_y, hi_x, hi_y;
    logic          live;

    always_comb begin
        lo_x = crop_en ? off_l : '0;
        lo_y = crop_en ? off_t : '0;
        hi_x = frame_w - (crop_en ? rem_r : '0);
        hi_y = frame_h - (crop_en ? rem_b : '0);
        win_w = hi_x - lo_x;

        live      = stb & hr & ~vs;
        in_win    = live && (p_q.x >= lo_x) && (p_q.x < hi_x)
                         && (p_q.y >= lo_y) && (p_q.y < hi_y);
        at_first  = in_win && (p_q.x == lo_x) && (p_q.y == lo_y);
        at_last   = in_win && (p_q.x == hi_x - ONE) && (p_q.y == hi_y - ONE);
        frame_go  = stb & vs & ~p_q.vs_prev;
        line_idle = stb & ~hr;

        p_d = p_q;
        if (stb) begin
            p_d.vs_prev = vs;
            p_d.hr_prev = hr;
            if (vs) begin
                p_d.x = '0;
                p_d.y = '0;
            end else if (hr) begin
                p_d.x = p_q.x + ONE;
            end else begin
                p_d.x = '0;
                if (p_q.hr_prev) p_d.y = p_q.y + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/cam_bars.sv
module cam_bars #(
    parameter int DW = 10,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          clr,
    input  logic [CW-1:0] win_w,
    output logic [DW-1:0] colour
);
    localparam int unsigned   STEP  = ((2 ** DW) - 1) / (cam_front_pkg::NUM_BARS - 1);
    localparam logic [CW:0]   EIGHT = (CW+1)'(cam_front_pkg::NUM_BARS);

    typedef struct packed {
        logic [CW-1:0] acc;
        logic [2:0]    bar;
    } bar_t;

    bar_t b_d, b_q;
    logic [CW:0] sum;

    always_comb begin
        b_d = b_q;
        sum = {1'b0, b_q.acc} + EIGHT;
        // Bar index tracks floor(8k/W) with a remainder accumulator
        if (clr) begin
            b_d = '0;
        end else if (adv) begin
            if (sum >= {1'b0, win_w}) begin
                b_d.acc = CW'(sum - {1'b0, win_w});
                if (b_q.bar != 3'd7) b_d.bar = b_q.bar + 3'd1;
            end else begin
                b_d.acc = CW'(sum);
            end
        end
        colour = DW'({29'd0, ~b_q.bar} * STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end
endmodule

// File: rtl/cam_irq.sv
module cam_irq
    import cam_front_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ev_vec_t ev_set,
    input  ev_vec_t ev_clr,
    input  ev_vec_t dis,
    input  logic    to_mem,
    output ev_vec_t pend,
    output logic    irq
);
    ev_vec_t pend_d, pend_q;
    ev_vec_t allow;

    always_comb begin
        // New events win over a clear in the same cycle
        pend_d = (pend_q & ~ev_clr) | ev_set;
        allow  = to_mem ? '1 : ev_vec_t'((1 << EV_OVF) | (1 << EV_LAST));
        irq    = |(pend_q & ~dis & allow);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/cam_crop_front.sv
module cam_crop_front
    import cam_front_pkg::*;
#(
    parameter int DW = 10,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cam_pclk,
    input  logic          cam_vsync,
    input  logic          cam_href,
    input  logic [DW-1:0] cam_data,
    input  logic          cfg_parallel,
    input  logic          cfg_pclk_fall,
    input  logic          cfg_vsync_low,
    input  logic          cfg_href_low,
    input  logic [CW-1:0] cfg_frame_w,
    input  logic [CW-1:0] cfg_frame_h,
    input  logic          cfg_crop_en,
    input  logic [CW-1:0] cfg_off_left,
    input  logic [CW-1:0] cfg_off_top,
    input  logic [CW-1:0] cfg_rem_right,
    input  logic [CW-1:0] cfg_rem_bottom,
    input  logic          cfg_capture_en,
    input  logic          cfg_test_bars,
    input  logic          cfg_to_mem,
    input  logic [3:0]    cfg_irq_dis,
    input  logic [3:0]    sts_clr,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sof,
    output logic          out_eof,
    output logic [3:0]    sts_pend,
    output logic          irq
);
    typedef struct packed {
        logic          cap_act;
        logic          vld;
        logic          sof;
        logic          eof;
        logic [DW-1:0] dat;
    } out_t;

    out_t    o_d, o_q;
    ev_vec_t ev;

    logic          pix_stb, vs_act, hr_act;
    logic [DW-1:0] pix_data, bar_colour;
    logic          in_win, at_first, at_last, frame_go, line_idle;
    logic [CW-1:0] win_w;

    cam_sync_edge #(.DW(DW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cam_pclk (cam_pclk),
        .cam_vsync(cam_vsync),
        .cam_href (cam_href),
        .cam_data (cam_data),
        .sel_par  (cfg_parallel),
        .inv_pclk (cfg_pclk_fall),
        .inv_vs   (cfg_vsync_low),
        .inv_hr   (cfg_href_low),
        .pix_stb  (pix_stb),
        .vs_act   (vs_act),
        .hr_act   (hr_act),
        .pix_data (pix_data)
    );

    cam_window #(.CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (pix_stb),
        .vs       (vs_act),
        .hr       (hr_act),
        .crop_en  (cfg_crop_en),
        .frame_w  (cfg_frame_w),
        .frame_h  (cfg_frame_h),
        .off_l    (cfg_off_left),
        .off_t    (cfg_off_top),
        .rem_r    (cfg_rem_right),
        .rem_b    (cfg_rem_bottom),
        .in_win   (in_win),
        .at_first (at_first),
        .at_last  (at_last),
        .frame_go (frame_go),
        .line_idle(line_idle),
        .win_w    (win_w)
    );

    cam_bars #(.DW(DW), .CW(CW)) u_bars (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_win),
        .clr   (line_idle | frame_go),
        .win_w (win_w),
        .colour(bar_colour)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = 1'b0;
        o_d.sof = 1'b0;
        o_d.eof = 1'b0;
        ev      = '0;

        // Capture enable is only taken at a frame boundary
        if (frame_go) begin
            o_d.cap_act  = cfg_capture_en;
            ev[EV_START] = cfg_capture_en;
        end

        if (in_win && o_q.cap_act) begin
            if (out_ready) begin
                o_d.vld = 1'b1;
                o_d.sof = at_first;
                o_d.eof = at_last;
                o_d.dat = cfg_test_bars ? bar_colour : pix_data;
            end else begin
                ev[EV_OVF] = 1'b1;
            end
            if (at_last) begin
                ev[EV_END]  = 1'b1;
                ev[EV_LAST] = ~cfg_capture_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    cam_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_set(ev),
        .ev_clr(sts_clr),
        .dis   (cfg_irq_dis),
        .to_mem(cfg_to_mem),
        .pend  (sts_pend),
        .irq   (irq)
    );

    assign out_valid = o_q.vld;
    assign out_sof   = o_q.sof;
    assign out_eof   = o_q.eof;
    assign out_data  = o_q.dat;
endmodule

// File: rtl/cam_front_chk.sv
module cam_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_ready,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic [3:0] sts_pend,
    input logic [3:0] sts_clr,
    input logic       irq,
    input logic       cfg_to_mem
);
    a_r8_valid_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_ready));

    a_r6_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    a_r8_drop_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_pend[0]) |-> !out_valid);

    a_r9_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sts_pend) & ~$past(sts_clr) & ~sts_pend) == 4'b0000);

    a_r10_downstream_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_to_mem && sts_pend[1:0] == 2'b00) |-> !irq);
endmodule

bind cam_crop_front cam_front_chk u_chk (.*);

// File: tb/cam_crop_front_test.sv
module cam_crop_front_test;
    localparam int DW = 10;
    localparam int CW = 12;
    localparam int STEP = ((1 << DW) - 1) / 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cam_pclk = 1'b0, cam_vsync = 1'b0, cam_href = 1'b0;
    logic [DW-1:0] cam_data = '0;
    logic cfg_parallel = 1'b1, cfg_pclk_fall = 1'b0, cfg_vsync_low = 1'b0, cfg_href_low = 1'b0;
    logic [CW-1:0] cfg_frame_w = 12, cfg_frame_h = 6;
    logic cfg_crop_en = 1'b0;
    logic [CW-1:0] cfg_off_left = '0, cfg_off_top = '0, cfg_rem_right = '0, cfg_rem_bottom = '0;
    logic cfg_capture_en = 1'b1, cfg_test_bars = 1'b0, cfg_to_mem = 1'b1;
    logic [3:0] cfg_irq_dis = 4'b0000, sts_clr = 4'b0000;
    logic out_ready = 1'b1;
    logic out_valid, out_sof, out_eof, irq;
    logic [DW-1:0] out_data;
    logic [3:0] sts_pend;

    int checks = 0, errors = 0;
    int ncol = 0;
    logic [DW-1:0] cd [256];
    bit cs [256];
    bit ce [256];
    bit done = 1'b0;

    always #5 clk = ~clk;

    cam_crop_front #(.DW(DW), .CW(CW)) uut (.*);

    always @(negedge clk) begin
        if (out_valid) begin
            if (ncol < 256) begin
                cd[ncol] = out_data;
                cs[ncol] = out_sof;
                ce[ncol] = out_eof;
            end
            ncol++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pix(input bit va, input bit ha, input int dv, input bit rdy);
        @(negedge clk);
        cam_pclk  = cfg_parallel & cfg_pclk_fall;
        cam_vsync = va ^ (cfg_parallel & cfg_vsync_low);
        cam_href  = ha ^ (cfg_parallel & cfg_href_low);
        cam_data  = DW'(dv);
        out_ready = rdy;
        repeat (2) @(negedge clk);
        cam_pclk = ~cam_pclk;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input int fw, input int fh, input int stop_row, input int dr, input int dc);
        @(negedge clk);
        ncol = 0;
        cfg_frame_w = CW'(fw);
        cfg_frame_h = CW'(fh);
        pix(1, 0, 0, 1);
        pix(0, 0, 0, 1);
        for (int r = 0; r < fh; r++) begin
            if (r == stop_row) cfg_capture_en = 1'b0;
            for (int c = 0; c < fw; c++)
                pix(0, 1, r * 16 + c + 1, !(r == dr && c == dc));
            pix(0, 0, 0, 1);
        end
        pix(0, 0, 0, 1);
    endtask

    task automatic verify(input string req, input int fw, input int fh,
                          input int dr, input int dc, input bit none);
        int l, t, xe, ye, w, n, bad, bact, bexp, sofs, eofs;
        l  = cfg_crop_en ? int'(cfg_off_left) : 0;
        t  = cfg_crop_en ? int'(cfg_off_top) : 0;
        xe = fw - (cfg_crop_en ? int'(cfg_rem_right) : 0);
        ye = fh - (cfg_crop_en ? int'(cfg_rem_bottom) : 0);
        w  = xe - l;
        n = 0; bad = 0; bact = 0; bexp = 0;
        if (!none) begin
            for (int y = t; y < ye; y++) begin
                for (int x = l; x < xe; x++) begin
                    int e;
                    if (y == dr && x == dc) continue;
                    e = cfg_test_bars ? (7 - (8 * (x - l)) / w) * STEP : y * 16 + x + 1;
                    if (n < 256 && int'(cd[n]) != e) begin
                        if (bad == 0) begin bact = int'(cd[n]); bexp = e; end
                        bad++;
                    end
                    n++;
                end
            end
        end
        chk(ncol == n, {req, " pixel count"}, ncol, n);
        chk(bad == 0, {req, " pixel data"}, bact, bexp);
        if (n > 0 && ncol == n) begin
            sofs = 0; eofs = 0;
            for (int i = 0; i < n; i++) begin
                sofs += int'(cs[i]);
                eofs += int'(ce[i]);
            end
            // R6: one marker each, at the ends of the stream
            chk(cs[0] && sofs == 1, "R6 sof marker", sofs, 1);
            chk(ce[n-1] && eofs == 1, "R6 eof marker", eofs, 1);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk);
        sts_clr = 4'hF;
        @(negedge clk);
        sts_clr = 4'h0;
        @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0 && out_sof == 0 && out_eof == 0, "R1 outputs", int'(out_valid), 0);
        chk(sts_pend == 0 && irq == 0, "R1 flags", int'(sts_pend), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: cropped window, rising edge, active-high syncs
        cfg_crop_en = 1; cfg_off_left = 2; cfg_off_top = 1; cfg_rem_right = 3; cfg_rem_bottom = 2;
        frame(12, 6, -1, -1, -1);
        verify("R4", 12, 6, -1, -1, 0);
        chk(sts_pend == 4'b1100, "R9 start and end flags", int'(sts_pend), 12);
        chk(irq == 1, "R10 memory mode irq", int'(irq), 1);
        clear_flags();
        chk(sts_pend == 0 && irq == 0, "R9 clear", int'(sts_pend), 0);

        // R5: crop disabled, offsets left programmed
        cfg_crop_en = 0;
        frame(12, 6, -1, -1, -1);
        verify("R5", 12, 6, -1, -1, 0);

        // R2: all three polarities inverted on the parallel bus
        cfg_pclk_fall = 1; cfg_vsync_low = 1; cfg_href_low = 1;
        cfg_crop_en = 1; cfg_off_left = 0; cfg_off_top = 0; cfg_rem_right = 1; cfg_rem_bottom = 1;
        frame(10, 5, -1, -1, -1);
        verify("R2", 10, 5, -1, -1, 0);
        // R2: only the vsync polarity inverted
        cfg_pclk_fall = 0; cfg_href_low = 0;
        frame(10, 5, -1, -1, -1);
        verify("R2 vsync only", 10, 5, -1, -1, 0);

        // R3: serial selection ignores the polarity bits
        cfg_parallel = 0; cfg_pclk_fall = 1; cfg_vsync_low = 1; cfg_href_low = 1;
        frame(10, 5, -1, -1, -1);
        verify("R3", 10, 5, -1, -1, 0);
        cfg_parallel = 1; cfg_pclk_fall = 0; cfg_vsync_low = 0; cfg_href_low = 0;
        clear_flags();

        // R8: overflow drops one pixel, downstream mode raises irq for it
        cfg_to_mem = 0;
        cfg_off_left = 2; cfg_off_top = 1; cfg_rem_right = 2; cfg_rem_bottom = 1;
        frame(12, 6, -1, 2, 4);
        verify("R8", 12, 6, 2, 4, 0);
        chk(sts_pend == 4'b1101, "R8 overflow flag", int'(sts_pend), 13);
        chk(irq == 1, "R10 overflow irq downstream", int'(irq), 1);
        clear_flags();

        // R10: downstream mode masks start and end
        frame(12, 6, -1, -1, -1);
        chk(sts_pend == 4'b1100, "R10 pending downstream", int'(sts_pend), 12);
        chk(irq == 0, "R10 downstream masked", int'(irq), 0);
        @(negedge clk); cfg_to_mem = 1; cfg_irq_dis = 4'b1100;
        @(negedge clk);
        chk(irq == 0, "R10 disable bits", int'(irq), 0);
        cfg_irq_dis = 4'b0100;
        @(negedge clk);
        chk(irq == 1, "R10 end enabled", int'(irq), 1);
        cfg_irq_dis = 4'b0000;
        clear_flags();

        // R7: frame started with capture off emits nothing
        cfg_capture_en = 0;
        frame(12, 6, -1, -1, -1);
        verify("R7 idle", 12, 6, -1, -1, 1);
        chk(sts_pend == 0, "R7 no flags", int'(sts_pend), 0);
        // R7: clearing mid-frame lets the frame finish, flags last capture
        cfg_capture_en = 1;
        frame(12, 6, 2, -1, -1);
        verify("R7 finish", 12, 6, -1, -1, 0);
        chk(sts_pend == 4'b1110, "R9 last capture flag", int'(sts_pend), 14);
        frame(12, 6, -1, -1, -1);
        verify("R7 stopped", 12, 6, -1, -1, 1);
        cfg_capture_en = 1;
        clear_flags();

        // R11: colour bars, window width 9 then 16
        cfg_test_bars = 1;
        cfg_off_left = 2; cfg_off_top = 0; cfg_rem_right = 1; cfg_rem_bottom = 3;
        frame(12, 5, -1, -1, -1);
        verify("R11 width 9", 12, 5, -1, -1, 0);
        cfg_crop_en = 0;
        frame(16, 2, -1, -1, -1);
        verify("R11 width 16", 16, 2, -1, -1, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule